// File: doc/BRIEF.md
# Battery Temperature Region Classifier

This block sorts a battery's temperature into one of five charging regions (cold, cool, nominal, warm, hot). Its input is the thermistor resistance in ohms, already digitised by a front end outside the block, and a strobe marks each new measurement. The thermistor is a 10 kΩ NTC part, so a higher resistance means a colder battery.

Each of the four region boundaries has two thresholds: one for moving into the colder region and one for moving back. The gap between them gives hysteresis, so a reading that sits near a boundary does not make the region chatter. From the current region, the block drives three signals for the charge controller:

- a charge-enable,
- a request for half the charge current,
- a request for a lowered termination voltage.

Top module: `thermal_zone_classifier`

## Requirements
- R1: After reset, `zone_valid` is 0, `charge_en` is 0, `cur_half` is 0 and `vterm_drop` is 0. These values hold until the first valid sample.
- R2: `zone` encodes the region as 0 = cold, 1 = cool, 2 = nominal, 3 = warm, 4 = hot. While `zone_valid` is 1, `zone` never takes any other value.
- R3: The first valid sample sets the region directly from the entry thresholds. The tests are applied in this priority order:
  - above 27280 Ω gives cold;
  - otherwise above 18000 Ω gives cool;
  - otherwise below 3020 Ω gives hot;
  - otherwise below 4920 Ω gives warm;
  - otherwise the region is nominal.
- R4: Cold/cool boundary. Cool moves to cold on a sample above 27280 Ω. Cold moves to cool only on a sample below 26000 Ω.
- R5: Cool/nominal boundary. Nominal moves to cool on a sample above 18000 Ω. Cool moves to nominal only on a sample below 17100 Ω.
- R6: Nominal/warm boundary. Nominal moves to warm on a sample below 4920 Ω. Warm moves to nominal only on a sample above 5130 Ω.
- R7: Warm/hot boundary. Warm moves to hot on a sample below 3020 Ω. Hot moves to warm only on a sample above 3190 Ω.
- R8: After initialisation, a valid sample moves the region by at most one step. A reading far outside the current region therefore walks through the regions in between, one sample at a time.
- R9: While `sample_valid` is low, the region holds, whatever `sample_ohms` carries.
- R10: In cold or hot, `charge_en`, `cur_half` and `vterm_drop` are all 0.
- R11: In cool, `charge_en` = 1, `cur_half` = 1 and `vterm_drop` = 0.
- R12: In warm, `charge_en` = 1, `cur_half` = 0 and `vterm_drop` = 1.
- R13: In nominal, `charge_en` = 1, `cur_half` = 0 and `vterm_drop` = 0.
- R14: A sample presented at a clock edge is reflected in `zone`, `zone_valid` and the action outputs right after that edge: one register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_valid | input | 1 | `sample_ohms` holds a new measurement this cycle |
| sample_ohms | input | RES_W | Thermistor resistance in ohms |
| zone | output | 3 | Current region code (see R2) |
| zone_valid | output | 1 | At least one valid sample has been taken since reset |
| charge_en | output | 1 | Charging allowed in the current region |
| cur_half | output | 1 | Request for half the charge-current limit |
| vterm_drop | output | 1 | Request for a lowered termination voltage |

## Verification
The assertions check the following on every cycle:

- the region code stays in range;
- the region never jumps more than one step;
- the region holds when no sample arrives;
- the three action outputs agree with the region;
- a boundary is crossed when the entry condition is met from the adjacent region.

Only the bench's scenarios can show the following, because each one depends on a sequence of samples rather than a single cycle:

- the exact hysteresis gaps, where a reading just inside the return threshold must not move the region;
- where the first sample lands;
- the walk through several regions after a large step.

// File: rtl/thz_pkg.sv
package thz_pkg;

    typedef enum logic [2:0] {
        Z_COLD = 3'd0,
        Z_COOL = 3'd1,
        Z_NOM  = 3'd2,
        Z_WARM = 3'd3,
        Z_HOT  = 3'd4
    } zone_e;

    localparam int NUM_ZONES = 5;
    localparam int NUM_EDGES = NUM_ZONES - 1;

    typedef struct packed {
        zone_e zone;
        logic  live;
    } cls_state_t;

endpackage

// File: rtl/thz_edge.sv
// One region boundary: flags a move toward the colder or the warmer side.
module thz_edge #(
    parameter int          W       = 16,
    parameter int unsigned TO_COLD = 27280,
    parameter int unsigned TO_WARM = 26000
) (
    input  logic [W-1:0] ohms,
    output logic         go_cold,
    output logic         go_warm
);
    localparam logic [W-1:0] COLD_LIM = TO_COLD[W-1:0];
    localparam logic [W-1:0] WARM_LIM = TO_WARM[W-1:0];

    always_comb begin
        // NTC: higher resistance means colder
        go_cold = (ohms > COLD_LIM);
        go_warm = (ohms < WARM_LIM);
    end
endmodule

// File: rtl/thz_step.sv
// Next-region selection: initial placement, or a single step toward a neighbour.
module thz_step
    import thz_pkg::*;
(
    input  zone_e                cur,
    input  logic                 live,
    input  logic [NUM_EDGES-1:0] go_cold,
    input  logic [NUM_EDGES-1:0] go_warm,
    output zone_e                nxt
);
    always_comb begin
        nxt = cur;
        if (!live) begin
            if (go_cold[0])                nxt = Z_COLD;
            else if (go_cold[1])           nxt = Z_COOL;
            else if (go_warm[NUM_EDGES-1]) nxt = Z_HOT;
            else if (go_warm[NUM_EDGES-2]) nxt = Z_WARM;
            else                           nxt = Z_NOM;
        end else begin
            // edge e separates region e (colder side) from region e+1
            for (int e = 0; e < NUM_EDGES; e++) begin
                if (cur == zone_e'(3'(e + 1)) && go_cold[e]) nxt = zone_e'(3'(e));
                if (cur == zone_e'(3'(e)) && go_warm[e])     nxt = zone_e'(3'(e + 1));
            end
        end
    end
endmodule

// File: rtl/thz_action.sv
// Maps the registered region to the charge-controller requests.
module thz_action
    import thz_pkg::*;
(
    input  zone_e zone,
    input  logic  live,
    output logic  charge_en,
    output logic  cur_half,
    output logic  vterm_drop
);
    always_comb begin
        charge_en  = 1'b0;
        cur_half   = 1'b0;
        vterm_drop = 1'b0;
        if (live) begin
            unique case (zone)
                Z_COOL: begin
                    charge_en = 1'b1;
                    cur_half  = 1'b1;
                end
                Z_NOM:  charge_en = 1'b1;
                Z_WARM: begin
                    charge_en  = 1'b1;
                    vterm_drop = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/thermal_zone_classifier.sv
module thermal_zone_classifier
    import thz_pkg::*;
#(
    parameter int          RES_W         = 16,
    parameter int unsigned COLD_ENTER    = 27280,
    parameter int unsigned COLD_LEAVE    = 26000,
    parameter int unsigned COOL_ENTER    = 18000,
    parameter int unsigned COOL_LEAVE    = 17100,
    parameter int unsigned WARM_ENTER    = 4920,
    parameter int unsigned WARM_LEAVE    = 5130,
    parameter int unsigned HOT_ENTER     = 3020,
    parameter int unsigned HOT_LEAVE     = 3190
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_valid,
    input  logic [RES_W-1:0] sample_ohms,
    output logic [2:0]       zone,
    output logic             zone_valid,
    output logic             charge_en,
    output logic             cur_half,
    output logic             vterm_drop
);
    // per boundary, colder-side threshold and warmer-side threshold
    localparam int unsigned TO_COLD_TAB [NUM_EDGES] =
        '{COLD_ENTER, COOL_ENTER, WARM_LEAVE, HOT_LEAVE};
    localparam int unsigned TO_WARM_TAB [NUM_EDGES] =
        '{COLD_LEAVE, COOL_LEAVE, WARM_ENTER, HOT_ENTER};

    logic [NUM_EDGES-1:0] go_cold;
    logic [NUM_EDGES-1:0] go_warm;
    zone_e                zone_nxt;
    cls_state_t           st_d, st_q;

    for (genvar g = 0; g < NUM_EDGES; g++) begin : g_edge
        thz_edge #(
            .W       (RES_W),
            .TO_COLD (TO_COLD_TAB[g]),
            .TO_WARM (TO_WARM_TAB[g])
        ) u_edge (
            .ohms    (sample_ohms),
            .go_cold (go_cold[g]),
            .go_warm (go_warm[g])
        );
    end

    thz_step u_step (
        .cur     (st_q.zone),
        .live    (st_q.live),
        .go_cold (go_cold),
        .go_warm (go_warm),
        .nxt     (zone_nxt)
    );

    always_comb begin
        st_d = st_q;
        if (sample_valid) begin
            st_d.zone = zone_nxt;
            st_d.live = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.zone <= Z_NOM;
            st_q.live <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    thz_action u_action (
        .zone       (st_q.zone),
        .live       (st_q.live),
        .charge_en  (charge_en),
        .cur_half   (cur_half),
        .vterm_drop (vterm_drop)
    );

    assign zone       = st_q.zone;
    assign zone_valid = st_q.live;
endmodule

// File: rtl/thz_checker.sv
module thz_checker #(
    parameter int          W          = 16,
    parameter int unsigned COLD_ENTER = 27280,
    parameter int unsigned HOT_ENTER  = 3020
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sample_valid,
    input logic [W-1:0] sample_ohms,
    input logic [2:0]   zone,
    input logic         zone_valid,
    input logic         charge_en,
    input logic         cur_half,
    input logic         vterm_drop
);
    localparam logic [W-1:0] COLD_LIM = COLD_ENTER[W-1:0];
    localparam logic [W-1:0] HOT_LIM  = HOT_ENTER[W-1:0];

    // R1
    idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !zone_valid |-> (!charge_en && !cur_half && !vterm_drop));

    // R2
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zone_valid |-> (zone <= 3'd4));

    // R4
    cold_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && zone_valid && zone == 3'd1 && sample_ohms > COLD_LIM) |=> (zone == 3'd0));

    // R7
    hot_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && zone_valid && zone == 3'd3 && sample_ohms < HOT_LIM) |=> (zone == 3'd4));

    // R8
    one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zone_valid |=> (zone == $past(zone) || zone == $past(zone) + 3'd1 || zone + 3'd1 == $past(zone)));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zone_valid && !sample_valid) |=> $stable(zone));

    // R10
    no_charge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zone_valid && (zone == 3'd0 || zone == 3'd4)) |-> (!charge_en && !cur_half && !vterm_drop));

    // R11
    cool_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zone_valid && zone == 3'd1) |-> (charge_en && cur_half && !vterm_drop));

    // R12
    warm_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zone_valid && zone == 3'd3) |-> (charge_en && !cur_half && vterm_drop));

    // R13
    nom_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zone_valid && zone == 3'd2) |-> (charge_en && !cur_half && !vterm_drop));

    // R14
    first_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!zone_valid && sample_valid) |=> zone_valid);
endmodule

bind thermal_zone_classifier thz_checker #(
    .W          (RES_W),
    .COLD_ENTER (COLD_ENTER),
    .HOT_ENTER  (HOT_ENTER)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .sample_ohms  (sample_ohms),
    .zone         (zone),
    .zone_valid   (zone_valid),
    .charge_en    (charge_en),
    .cur_half     (cur_half),
    .vterm_drop   (vterm_drop)
);

// File: tb/sim_thermal_zone_classifier.sv
`timescale 1ns/1ps
module sim_thermal_zone_classifier;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic [15:0] sample_ohms = '0;
    logic [2:0]  zone;
    logic        zone_valid, charge_en, cur_half, vterm_drop;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    thermal_zone_classifier u0 (
        .clk (clk), .rst_n (rst_n), .sample_valid (sample_valid),
        .sample_ohms (sample_ohms), .zone (zone), .zone_valid (zone_valid),
        .charge_en (charge_en), .cur_half (cur_half), .vterm_drop (vterm_drop)
    );

    // behavioural reference: integer region index, thresholds written as ohms
    int m_zone = 2;
    bit m_live = 0;

    function automatic int model_next(int z, bit live, int r);
        if (!live) begin
            if (r > 27280) return 0;
            if (r > 18000) return 1;
            if (r < 3020)  return 4;
            if (r < 4920)  return 3;
            return 2;
        end
        case (z)
            0: return (r < 26000) ? 1 : 0;
            1: return (r > 27280) ? 0 : ((r < 17100) ? 2 : 1);
            2: return (r > 18000) ? 1 : ((r < 4920) ? 3 : 2);
            3: return (r > 5130) ? 2 : ((r < 3020) ? 4 : 3);
            default: return (r > 3190) ? 3 : 4;
        endcase
    endfunction

    task automatic note(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_live = 0;
            m_zone = 2;
        end else begin
            if (sample_valid) begin
                m_zone = model_next(m_zone, m_live, int'(sample_ohms));
                m_live = 1;
            end
            #1;
            // R8 R10 R11 R12 R13 cycle-by-cycle comparison with the model
            note("R8 model valid", int'(zone_valid), int'(m_live));
            if (m_live) note("R8 model zone", int'(zone), m_zone);
            note("R10 model charge_en", int'(charge_en), int'(m_live && m_zone >= 1 && m_zone <= 3));
            note("R11 model cur_half", int'(cur_half), int'(m_live && m_zone == 1));
            note("R12 model vterm_drop", int'(vterm_drop), int'(m_live && m_zone == 3));
        end
    end

    task automatic take(int r);
        @(negedge clk);
        sample_valid = 1'b1;
        sample_ohms  = 16'(r);
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic expect_zone(string tag, int z);
        note(tag, int'(zone), z);
        note({tag, " valid"}, int'(zone_valid), 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        note("R1 zone_valid", int'(zone_valid), 0);
        note("R1 charge_en", int'(charge_en), 0);
        note("R1 cur_half", int'(cur_half), 0);
        note("R1 vterm_drop", int'(vterm_drop), 0);
        rst_n = 1'b1;
        sample_ohms = 16'd40000;
        repeat (4) @(negedge clk);
        note("R9 no sample keeps invalid", int'(zone_valid), 0);
        note("R1 charge_en before sample", int'(charge_en), 0);

        // R3 first sample lands directly in cold
        take(30000);   expect_zone("R3 init cold", 0);
        note("R10 cold charge_en", int'(charge_en), 0);
        // R4 hysteresis at the cold/cool boundary
        take(26500);   expect_zone("R4 stays cold inside gap", 0);
        take(25999);   expect_zone("R4 back to cool", 1);
        note("R11 cool cur_half", int'(cur_half), 1);
        note("R11 cool vterm_drop", int'(vterm_drop), 0);
        take(27280);   expect_zone("R4 at entry value stays cool", 1);
        take(27281);   expect_zone("R4 enters cold", 0);
        take(20000);   expect_zone("R4 cold to cool", 1);
        // R5
        take(17500);   expect_zone("R5 stays cool inside gap", 1);
        take(17099);   expect_zone("R5 back to nominal", 2);
        note("R13 nominal charge_en", int'(charge_en), 1);
        note("R13 nominal cur_half", int'(cur_half), 0);
        take(18000);   expect_zone("R5 at entry value stays nominal", 2);
        take(18001);   expect_zone("R5 enters cool", 1);
        take(10000);   expect_zone("R5 cool to nominal", 2);
        // R6
        take(5000);    expect_zone("R6 nominal holds", 2);
        take(4919);    expect_zone("R6 enters warm", 3);
        note("R12 warm vterm_drop", int'(vterm_drop), 1);
        note("R12 warm charge_en", int'(charge_en), 1);
        take(5130);    expect_zone("R6 stays warm inside gap", 3);
        take(5131);    expect_zone("R6 back to nominal", 2);
        take(4000);    expect_zone("R6 nominal to warm", 3);
        // R7
        take(3100);    expect_zone("R7 warm holds", 3);
        take(3019);    expect_zone("R7 enters hot", 4);
        note("R10 hot charge_en", int'(charge_en), 0);
        take(3190);    expect_zone("R7 stays hot inside gap", 4);
        take(3191);    expect_zone("R7 back to warm", 3);
        // R8 large steps walk one region per sample
        take(40000);   expect_zone("R8 walk 1", 2);
        take(40000);   expect_zone("R8 walk 2", 1);
        take(40000);   expect_zone("R8 walk 3", 0);
        take(1000);    expect_zone("R8 walk back 1", 1);
        take(1000);    expect_zone("R8 walk back 2", 2);
        take(1000);    expect_zone("R8 walk back 3", 3);
        take(1000);    expect_zone("R8 walk back 4", 4);
        // R9 input changes without strobe
        @(negedge clk); sample_ohms = 16'd50000;
        repeat (5) @(negedge clk);
        expect_zone("R9 hold without strobe", 4);
        note("R9 charge_en held off", int'(charge_en), 0);

        // R14 single-cycle latency, R3 init into warm
        do_reset();
        sample_valid = 1'b1; sample_ohms = 16'd4500;
        #1 note("R14 not yet valid", int'(zone_valid), 0);
        @(negedge clk); sample_valid = 1'b0;
        expect_zone("R14 R3 init warm one edge later", 3);
        // R3 init hot, cool, nominal
        do_reset(); take(3000);  expect_zone("R3 init hot", 4);
        do_reset(); take(20000); expect_zone("R3 init cool", 1);
        do_reset(); take(10000); expect_zone("R3 init nominal", 2);
        // R2 codes seen above; nominal after a gap-value start
        do_reset(); take(5000);  expect_zone("R2 R3 gap start nominal", 2);

        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule